// File: doc/BRIEF.md
# Default Register Bank with Temporary Override

This block is a bank of registers whose visible contents come, by default, from values fixed elsewhere on the chip (for example fuse storage). Each register shows its default until something replaces it. Before the bank is locked, writes behave like those of an ordinary register file. After the lock input is raised, a write can only install a temporary replacement, and only while an override-enable bit in a control register is set.

The rule for getting back to the defaults is deliberately per-register. Clearing the override enable changes nothing on its own. A register that still holds a temporary value drops it only when it is itself written while the enable is clear. The data of that write is then discarded. A reset, which stands in for a power cycle, clears every replacement at once. The bus protocol and the default storage are outside the block. It sees write strobes, an address, data, the default values and the lock level, and it drives the effective value of every register.

Top module: `ovr_default_bank`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every register's effective value equals its default input.
- R2: With lock low, a write stores its data in the addressed register, whatever the override-enable bit holds.
- R3: With lock high and the override-enable bit set, a write stores its data as the addressed register's temporary value, and that value becomes its effective output.
- R4: With lock high and the override-enable bit clear, a write to a register other than the control register makes it show its default again. The written data is ignored. This holds whether or not the register was overridden.
- R5: Clearing the override-enable bit reverts no register by itself. Every register not addressed by a write keeps the value it shows.
- R6: The control register is at address 22 (0x16) and holds the override enable in bit 3. It is directly writable in every lock and enable state.
- R7: A register that holds no written value follows its default input combinationally. A register with a stored value ignores changes to its default.
- R8: Writes to addresses at or above the register count (24..31) change no register.
- R9: A write becomes visible after the first rising clock edge at which it is presented, and changes only the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lock | input | 1 | High once the defaults are permanent |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 8 | Write data |
| dflt_flat | input | 192 | Default values, register i at bits [8*i+7:8*i] |
| eff_flat | output | 192 | Effective values, register i at bits [8*i+7:8*i] |

## Verification
The assertions check on every cycle that an accepted write lands in the addressed register and that a locked write with the enable clear leaves the register on its default. They also check that registers not addressed keep their stored state, that reset shows the defaults, that out-of-range addresses select nothing and that the control register always takes its data. Some behaviours show only in the bench's scenarios. One is the order-dependent history: a register overridden, the enable cleared, other registers written, and the register reverted later. Another is that a live change of a default shows through only on registers that hold no written value. The random phase compares the whole output vector against a reference model after every write.

// File: rtl/ovr_bank_pkg.sv
package ovr_bank_pkg;

  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_LOAD   = 2'd1,
    WR_REVERT = 2'd2
  } wr_act_e;

  // Action taken by one slot for one cycle's write.
  function automatic wr_act_e pick_action(input logic hit,
                                          input logic locked,
                                          input logic ovr_en,
                                          input logic always_direct);
    if (!hit) return WR_NONE;
    if (!locked || ovr_en || always_direct) return WR_LOAD;
    return WR_REVERT;
  endfunction

endpackage

// File: rtl/ovr_rst_sync.sv
module ovr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ovr_addr_decode.sv
module ovr_addr_decode #(
  parameter int NUM_REGS = 24,
  parameter int ADDR_W   = 5
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] hit
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign hit[i] = wr_en && (addr == ADDR_W'(i));
  end

  always_comb begin
    if (wr_en && (int'(addr) >= NUM_REGS))
      AST_OOR_NO_HIT: assert (hit == '0); // R8
    AST_HIT_ONEHOT: assert ($onehot0(hit)); // R9
  end

endmodule

// File: rtl/ovr_reg_slot.sv
module ovr_reg_slot
  import ovr_bank_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter bit ALWAYS_DIRECT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              locked,
  input  logic              ovr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dflt,
  output logic [DATA_W-1:0] eff
);

  logic              ovr_q, ovr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              ld;
  wr_act_e           act;

  // next state
  always_comb begin
    act    = pick_action(hit, locked, ovr_en, ALWAYS_DIRECT);
    ovr_d  = ovr_q;
    data_d = data_q;
    unique case (act)
      WR_LOAD: begin
        ovr_d  = 1'b1;
        data_d = wdata;
      end
      WR_REVERT: ovr_d = 1'b0;
      default: ;
    endcase
    ld = (act != WR_NONE);
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      data_q <= '0;
    end else if (ld) begin
      ovr_q  <= ovr_d;
      data_q <= data_d;
    end
  end

  assign eff = ovr_q ? data_q : dflt;

  AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && (!locked || ovr_en || ALWAYS_DIRECT)) |=> (eff == $past(wdata))); // R3

  AST_LOCKED_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && locked && !ovr_en && !ALWAYS_DIRECT) |=> (eff == dflt)); // R4

  AST_UNADDRESSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(ovr_q) && $stable(data_q))); // R5

  always_ff @(posedge clk) begin
    if (!rst_n) AST_RESET_DEFAULT: assert (eff == dflt); // R1
  end

endmodule

// File: rtl/ovr_default_bank.sv
module ovr_default_bank #(
  parameter int NUM_REGS  = 24,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 22,
  parameter int OVR_BIT   = 3,
  localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int FLAT_W   = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FLAT_W-1:0] dflt_flat,
  output logic [FLAT_W-1:0] eff_flat
);

  logic                rst_sync_n;
  logic [NUM_REGS-1:0] hit;
  logic [DATA_W-1:0]   eff_arr [NUM_REGS];
  logic                ovr_en;

  ovr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ovr_addr_decode #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .wr_en (wr_en),
    .addr  (wr_addr),
    .hit   (hit)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    ovr_reg_slot #(
      .DATA_W        (DATA_W),
      .ALWAYS_DIRECT (i == CTRL_ADDR)
    ) u_slot (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .hit    (hit[i]),
      .locked (lock),
      .ovr_en (ovr_en),
      .wdata  (wr_data),
      .dflt   (dflt_flat[i*DATA_W +: DATA_W]),
      .eff    (eff_arr[i])
    );
    assign eff_flat[i*DATA_W +: DATA_W] = eff_arr[i];
  end

  assign ovr_en = eff_arr[CTRL_ADDR][OVR_BIT];

  AST_CTRL_ALWAYS_WRITABLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && (wr_addr == ADDR_W'(CTRL_ADDR))) |=> (eff_arr[CTRL_ADDR] == $past(wr_data))); // R6

  AST_UNLOCKED_DIRECT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !lock && (int'(wr_addr) < NUM_REGS))
      |=> (eff_flat[int'($past(wr_addr))*DATA_W +: DATA_W] == $past(wr_data))); // R2

endmodule

// File: tb/tb_ovr_default_bank.sv
module tb_ovr_default_bank;

  localparam int N    = 24;
  localparam int DW   = 8;
  localparam int AW   = 5;
  localparam int CTRL = 22;
  localparam int OBIT = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lock;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [N*DW-1:0] dflt_flat;
  logic [N*DW-1:0] eff_flat;

  logic          m_flag [N];
  logic [DW-1:0] m_data [N];

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ovr_default_bank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock      (lock),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .dflt_flat (dflt_flat),
    .eff_flat  (eff_flat)
  );

  function automatic logic [DW-1:0] m_eff(int i);
    return m_flag[i] ? m_data[i] : dflt_flat[i*DW +: DW];
  endfunction

  function automatic logic [N*DW-1:0] m_flat();
    logic [N*DW-1:0] v;
    for (int i = 0; i < N; i++) v[i*DW +: DW] = m_eff(i);
    return v;
  endfunction

  function automatic void m_reset();
    for (int i = 0; i < N; i++) begin
      m_flag[i] = 1'b0;
      m_data[i] = '0;
    end
  endfunction

  function automatic void m_write(int a, logic [DW-1:0] d, logic lk);
    logic en;
    if (a >= N) return;
    en = m_eff(CTRL)[OBIT];
    if (!lk || en || a == CTRL) begin
      m_flag[a] = 1'b1;
      m_data[a] = d;
    end else begin
      m_flag[a] = 1'b0;
    end
  endfunction

  task automatic check_all(string tag);
    logic [N*DW-1:0] exp_v;
    exp_v = m_flat();
    checks++;
    if (eff_flat !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, eff_flat, exp_v);
    end
  endtask

  task automatic check_reg(string tag, int i, logic [DW-1:0] exp_v);
    checks++;
    if (eff_flat[i*DW +: DW] !== exp_v) begin
      fails++;
      $display("FAIL %s reg %0d: actual %h expected %h", tag, i, eff_flat[i*DW +: DW], exp_v);
    end
  endtask

  // Drive at a falling edge, let one rising edge take it, compare at the next falling edge.
  task automatic wr(int a, logic [DW-1:0] d, string tag);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(a);
    wr_data = d;
    m_write(a, d, lock);
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_reset();
    @(negedge clk);
    check_all("R1 during reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 after release");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n   = 1'b0;
    lock    = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    for (int i = 0; i < N; i++) dflt_flat[i*DW +: DW] = DW'(8'h40 + i);
    dflt_flat[CTRL*DW +: DW] = 8'h00;
    m_reset();
    repeat (2) @(negedge clk);
    check_all("R1 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 released");

    // R2: unlocked writes are direct, whatever the enable
    wr(5, 8'hA5, "R2 unlocked write");
    wr(CTRL, 8'h08, "R6 set enable");
    wr(6, 8'h5A, "R2 unlocked write with enable set");

    // R3: locked, enable set
    lock = 1'b1;
    wr(7, 8'h3C, "R3 locked override");
    wr(5, 8'h11, "R3 locked rewrite");
    check_reg("R3 reg7 value", 7, 8'h3C);

    // R5/R6: clear enable while locked
    wr(CTRL, 8'h00, "R6 clear enable while locked");
    check_reg("R5 reg7 kept", 7, 8'h3C);
    check_reg("R5 reg5 kept", 5, 8'h11);

    // R4: locked, enable clear -> revert, data ignored
    wr(7, 8'hFF, "R4 revert reg7");
    check_reg("R4 reg7 default", 7, dflt_flat[7*DW +: DW]);
    check_reg("R5 reg5 still overridden", 5, 8'h11);
    wr(9, 8'hEE, "R4 write to non-overridden reg");
    check_reg("R4 reg9 default", 9, dflt_flat[9*DW +: DW]);

    // R6: control reg writable when locked and enable clear
    wr(CTRL, 8'h08, "R6 re-enable while locked");
    wr(9, 8'h77, "R3 override after re-enable");

    // R8: out-of-range addresses
    wr(24, 8'h99, "R8 addr 24 ignored");
    wr(31, 8'h98, "R8 addr 31 ignored");

    // R7: live defaults
    @(negedge clk);
    dflt_flat[7*DW +: DW] = 8'hC3;
    dflt_flat[5*DW +: DW] = 8'h01;
    #1;
    check_reg("R7 reg7 follows default", 7, 8'hC3);
    check_reg("R7 reg5 ignores default", 5, 8'h11);

    // R9: random mix against the model
    for (int k = 0; k < 400; k++) begin
      int a;
      if ($urandom_range(0, 9) == 0) lock = ~lock;
      if ($urandom_range(0, 7) == 0) a = CTRL;
      else a = $urandom_range(0, 31);
      if ($urandom_range(0, 15) == 0) begin
        @(negedge clk);
        dflt_flat[$urandom_range(0, N-1)*DW +: DW] = DW'($urandom);
      end
      wr(a, DW'($urandom), "R9 random write");
    end

    // R1: reset mid-run clears all overrides
    do_reset();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule